// File: doc/BRIEF.md
# Timestamp Counter Preset and Sync

This block keeps a node's 64-bit timestamp counter in step with every other node of a tree-shaped timing network. Commands arrive already decoded from the serial link as an opcode with a 64-bit payload. A preset command only stores a pending start value. The counter is loaded from that stored value only when a later SYNC strobe takes effect. SYNC is issued solely by the tree's master. Each node holds SYNC back by its own programmable delay-compensation offset, so that all nodes load on the same absolute clock cycle. Once loaded, the counter advances by one every clock.

The master can later broadcast the count it expects. The block compares that value with its own count and keeps a sticky mismatch flag. Link commands can also write a small bank of 32-bit control registers. Register 0 holds the SYNC delay offset. A SYNC that takes effect with no preset waiting is dropped and counted.

Top module: `tstamp_align`

## Requirements
- R1: After reset the count is 0, the counter is stopped, and no preset is pending. The mismatch flag, the SYNC error count and every control register are 0.
- R2: A command with opcode 0x01 stores payload[63:0] as the pending start value and raises `preset_pending` on the next cycle. It does not change the count, and a stopped counter stays stopped.
- R3: A SYNC that takes effect while a preset is pending does three things. It loads the pending value into the count, clears `preset_pending` and sets `running`. From then on the count rises by exactly one per clock.
- R4: Data bits [7:0] of control register 0 hold the delay offset D. A SYNC strobe sampled in cycle k takes effect in cycle k+1+D. With a preset pending, the count therefore shows the preset value in cycle k+2+D and not earlier.
- R5: A SYNC that takes effect with no preset pending leaves the count and `running` unchanged. It raises `sync_err_cnt` by one, and the count saturates at its maximum.
- R6: A command with opcode 0x02 compares payload[63:0] with the count in the same cycle. A difference sets `mismatch` from the next cycle on, and an equal value leaves it clear. Once set, the flag stays set.
- R7: Only a SYNC that loads a pending preset clears `mismatch`. A preset alone does not clear it.
- R8: A command with opcode 0x03 writes payload[31:0] into the control register whose index is payload[39:32]. The new value shows on `ctrl_bank` (register i in bits [32i+31:32i]) from the next cycle. Indices at or above the register count change nothing.
- R9: Other opcode values, and any opcode presented while `cmd_valid` is low, have no effect.
- R10: A SYNC strobe that arrives while an earlier SYNC is still waiting out its delay is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 8 | Command opcode |
| cmd_payload | input | 64 | Command payload |
| sync_in | input | 1 | SYNC strobe from the link |
| count | output | 64 | Timestamp counter |
| running | output | 1 | Counter has been started |
| preset_pending | output | 1 | A start value waits for SYNC |
| mismatch | output | 1 | Sticky verify-difference flag |
| sync_err_cnt | output | 8 | SYNCs seen with no preset pending |
| ctrl_bank | output | 128 | Control registers, register 0 lowest |

## Verification
The load path is tried with offsets of 0, 3 and 5 cycles. The cycle on which the preset value first appears separates a correct delay from one that is off by one. A second strobe placed inside the delay window shows whether the wait is restarted or ignored. Verify is driven once with the exact running count and once with a wrong value, which separates a real comparison from a stuck flag. A preset sent after the mismatch shows that the flag clears only on the load. SYNC is also sent with no preset pending, both while the counter is stopped and while it runs, to check that the count is untouched while the error count rises.

// File: rtl/tsa_pkg.sv
package tsa_pkg;

    localparam int OP_W      = 8;
    localparam int PAYLOAD_W = 64;
    localparam int ADDR_LSB  = 32;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 32;

    typedef enum logic [OP_W-1:0] {
        OP_PRESET = 8'h01,
        OP_VERIFY = 8'h02,
        OP_REGWR  = 8'h03
    } tsa_op_e;

    typedef struct packed {
        logic                 preset;
        logic                 verify;
        logic                 regwr;
        logic [ADDR_W-1:0]    addr;
        logic [DATA_W-1:0]    data;
        logic [PAYLOAD_W-1:0] value;
    } tsa_cmd_t;

    function automatic tsa_cmd_t decode_cmd(input logic            vld,
                                            input logic [OP_W-1:0] op,
                                            input logic [PAYLOAD_W-1:0] pl);
        tsa_cmd_t c;
        c.preset = 1'b0;
        c.verify = 1'b0;
        c.regwr  = 1'b0;
        c.addr   = pl[ADDR_LSB +: ADDR_W];
        c.data   = pl[DATA_W-1:0];
        c.value  = pl;
        if (vld) begin
            case (tsa_op_e'(op))
                OP_PRESET: c.preset = 1'b1;
                OP_VERIFY: c.verify = 1'b1;
                OP_REGWR:  c.regwr  = 1'b1;
                default:   ;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/tsa_cmd_decode.sv
module tsa_cmd_decode
    import tsa_pkg::*;
(
    input  logic                 cmd_valid,
    input  logic [OP_W-1:0]      cmd_op,
    input  logic [PAYLOAD_W-1:0] cmd_payload,
    output tsa_cmd_t             cmd
);
    always_comb cmd = decode_cmd(cmd_valid, cmd_op, cmd_payload);
endmodule

// File: rtl/tsa_regbank.sv
module tsa_regbank
    import tsa_pkg::*;
#(
    parameter int NREG  = 4,
    parameter int DLY_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    output logic [NREG*DATA_W-1:0] bank,
    output logic [DLY_W-1:0]       sync_dly
);
    for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
        localparam logic [ADDR_W-1:0] IDX = ADDR_W'(gi);
        logic [DATA_W-1:0] r_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                r_q <= '0;
            end else if (wr_en && wr_addr == IDX) begin
                r_q <= wr_data;
            end
        end
        assign bank[gi*DATA_W +: DATA_W] = r_q;
    end

    assign sync_dly = bank[DLY_W-1:0];
endmodule

// File: rtl/tsa_sync_delay.sv
module tsa_sync_delay #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_in,
    input  logic [DLY_W-1:0] dly,
    output logic             fire
);
    logic             armed;
    logic [DLY_W-1:0] remain;
    logic             fire_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed  <= 1'b0;
            remain <= '0;
            fire_q <= 1'b0;
        end else begin
            fire_q <= 1'b0;
            if (armed) begin
                remain <= remain - 1'b1;
                if (remain == DLY_W'(1)) begin
                    fire_q <= 1'b1;
                    armed  <= 1'b0;
                end
            end else if (sync_in) begin
                if (dly == '0) begin
                    fire_q <= 1'b1;
                end else begin
                    armed  <= 1'b1;
                    remain <= dly;
                end
            end
        end
    end

    assign fire = fire_q;
endmodule

// File: rtl/tsa_counter.sv
module tsa_counter
    import tsa_pkg::*;
#(
    parameter int ERR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 preset,
    input  logic                 verify,
    input  logic [PAYLOAD_W-1:0] value,
    input  logic                 fire,
    output logic [PAYLOAD_W-1:0] count,
    output logic                 running,
    output logic                 pend_q,
    output logic [PAYLOAD_W-1:0] pend_val,
    output logic                 mismatch,
    output logic [ERR_W-1:0]     err_cnt
);
    logic load;
    logic orphan;

    assign load   = fire && pend_q;
    assign orphan = fire && !pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count    <= '0;
            running  <= 1'b0;
            pend_q   <= 1'b0;
            pend_val <= '0;
            mismatch <= 1'b0;
            err_cnt  <= '0;
        end else begin
            if (preset) begin
                pend_q   <= 1'b1;
                pend_val <= value;
            end else if (load) begin
                pend_q   <= 1'b0;
            end

            if (load) begin
                count   <= pend_val;
                running <= 1'b1;
            end else if (running) begin
                count   <= count + 1'b1;
            end

            if (load) begin
                mismatch <= 1'b0;
            end else if (verify && value != count) begin
                mismatch <= 1'b1;
            end

            if (orphan && err_cnt != '1) begin
                err_cnt <= err_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tstamp_align.sv
module tstamp_align
    import tsa_pkg::*;
#(
    parameter int NREG  = 4,
    parameter int DLY_W = 8,
    parameter int ERR_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cmd_valid,
    input  logic [OP_W-1:0]        cmd_op,
    input  logic [PAYLOAD_W-1:0]   cmd_payload,
    input  logic                   sync_in,
    output logic [PAYLOAD_W-1:0]   count,
    output logic                   running,
    output logic                   preset_pending,
    output logic                   mismatch,
    output logic [ERR_W-1:0]       sync_err_cnt,
    output logic [NREG*DATA_W-1:0] ctrl_bank
);
    tsa_cmd_t             cmd;
    logic [DLY_W-1:0]     sync_dly;
    logic                 sync_fire;
    logic                 pend_q;
    logic [PAYLOAD_W-1:0] pend_val;

    tsa_cmd_decode i_dec (
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_payload (cmd_payload),
        .cmd         (cmd)
    );

    tsa_regbank #(.NREG(NREG), .DLY_W(DLY_W)) i_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cmd.regwr),
        .wr_addr  (cmd.addr),
        .wr_data  (cmd.data),
        .bank     (ctrl_bank),
        .sync_dly (sync_dly)
    );

    tsa_sync_delay #(.DLY_W(DLY_W)) i_dly (
        .clk     (clk),
        .rst     (rst),
        .sync_in (sync_in),
        .dly     (sync_dly),
        .fire    (sync_fire)
    );

    tsa_counter #(.ERR_W(ERR_W)) i_cnt (
        .clk      (clk),
        .rst      (rst),
        .preset   (cmd.preset),
        .verify   (cmd.verify),
        .value    (cmd.value),
        .fire     (sync_fire),
        .count    (count),
        .running  (running),
        .pend_q   (pend_q),
        .pend_val (pend_val),
        .mismatch (mismatch),
        .err_cnt  (sync_err_cnt)
    );

    assign preset_pending = pend_q;
endmodule

// File: rtl/tsa_checker.sv
module tsa_checker
    import tsa_pkg::*;
#(
    parameter int ERR_W = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cmd_valid,
    input logic [OP_W-1:0]      cmd_op,
    input logic [PAYLOAD_W-1:0] cmd_payload,
    input logic                 sync_fire,
    input logic                 pend_q,
    input logic [PAYLOAD_W-1:0] pend_val,
    input logic [PAYLOAD_W-1:0] count,
    input logic                 running,
    input logic                 mismatch,
    input logic [ERR_W-1:0]     sync_err_cnt
);
    logic is_preset;
    logic is_verify;
    logic is_load;

    assign is_preset = cmd_valid && (cmd_op == OP_PRESET);
    assign is_verify = cmd_valid && (cmd_op == OP_VERIFY);
    assign is_load   = sync_fire && pend_q;

    // R2
    preset_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (is_preset && !is_load) |=> (pend_q &&
            count == ($past(running) ? $past(count) + 64'd1 : $past(count))));

    // R3
    sync_load_chk: assert property (@(posedge clk) disable iff (rst)
        is_load |=> (running && count == $past(pend_val) && !pend_q));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (running && !is_load) |=> (running && count == $past(count) + 64'd1));

    // R5
    orphan_sync_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_fire && !pend_q && sync_err_cnt != '1) |=>
            (sync_err_cnt == $past(sync_err_cnt) + 1'b1));

    // R6
    verify_diff_chk: assert property (@(posedge clk) disable iff (rst)
        (is_verify && cmd_payload != count && !is_load) |=> mismatch);

    // R6
    mismatch_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (mismatch && !is_load) |=> mismatch);

    // R7
    mismatch_clear_chk: assert property (@(posedge clk) disable iff (rst)
        is_load |=> !mismatch);
endmodule

bind tstamp_align tsa_checker #(.ERR_W(ERR_W)) i_chk (.*);

// File: tb/test_tstamp_align.sv
module test_tstamp_align;
    localparam int NREG = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [7:0]    cmd_op = '0;
    logic [63:0]   cmd_payload = '0;
    logic          sync_in = 1'b0;
    logic [63:0]   count;
    logic          running;
    logic          preset_pending;
    logic          mismatch;
    logic [7:0]    sync_err_cnt;
    logic [NREG*32-1:0] ctrl_bank;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    localparam int K_COUNT = 0, K_RUN = 1, K_PEND = 2, K_MIS = 3, K_ERR = 4, K_REG = 5;

    typedef struct {
        int          at;
        int          kind;
        int          idx;
        logic [63:0] exp;
        string       req;
    } sb_item_t;

    sb_item_t sbq[$];
    sb_item_t cur;

    tstamp_align i_tstamp_align (
        .clk            (clk),
        .rst            (rst),
        .cmd_valid      (cmd_valid),
        .cmd_op         (cmd_op),
        .cmd_payload    (cmd_payload),
        .sync_in        (sync_in),
        .count          (count),
        .running        (running),
        .preset_pending (preset_pending),
        .mismatch       (mismatch),
        .sync_err_cnt   (sync_err_cnt),
        .ctrl_bank      (ctrl_bank)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [63:0] actual(input int kind, input int idx);
        case (kind)
            K_COUNT: return count;
            K_RUN:   return {63'b0, running};
            K_PEND:  return {63'b0, preset_pending};
            K_MIS:   return {63'b0, mismatch};
            K_ERR:   return {56'b0, sync_err_cnt};
            default: return {32'b0, ctrl_bank[idx*32 +: 32]};
        endcase
    endfunction

    task automatic expect_at(input int at, input int kind, input int idx,
                             input logic [63:0] exp, input string req);
        sb_item_t it;
        int pos;
        it.at = at; it.kind = kind; it.idx = idx; it.exp = exp; it.req = req;
        pos = sbq.size();
        for (int i = 0; i < sbq.size(); i++) begin
            if (sbq[i].at > at) begin
                pos = i;
                break;
            end
        end
        sbq.insert(pos, it);
    endtask

    // monitor: pops items due in the current cycle
    always @(negedge clk) begin
        if (!rst) begin
            while (sbq.size() > 0 && sbq[0].at <= cyc) begin
                cur = sbq.pop_front();
                checks++;
                if (cur.at < cyc) begin
                    failures++;
                    $display("FAIL %s: check for cycle %0d missed (now %0d)", cur.req, cur.at, cyc);
                end else if (actual(cur.kind, cur.idx) !== cur.exp) begin
                    failures++;
                    $display("FAIL %s: kind %0d idx %0d actual %0h expected %0h",
                             cur.req, cur.kind, cur.idx, actual(cur.kind, cur.idx), cur.exp);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic send_cmd(input logic [7:0] op, input logic [63:0] pl, output int c);
        step();
        c = cyc;
        cmd_valid = 1'b1;
        cmd_op = op;
        cmd_payload = pl;
        step();
        cmd_valid = 1'b0;
        cmd_op = 8'h00;
        cmd_payload = '0;
    endtask

    task automatic send_sync(output int c);
        step();
        c = cyc;
        sync_in = 1'b1;
        step();
        sync_in = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    function automatic logic [63:0] regwr_pl(input logic [7:0] a, input logic [31:0] d);
        return {24'b0, a, d};
    endfunction

    initial begin
        int c;
        int s;
        int load_at;
        logic [63:0] p1, p2, p3;
        p1 = 64'h0000_0001_0000_1000;
        p2 = 64'h0000_00AB_CDEF_0000;
        p3 = 64'hFFFF_FFFF_FFFF_FFF8;

        wait_cycles(3);
        rst = 1'b0;
        step();
        // R1 reset state
        expect_at(cyc, K_COUNT, 0, 64'd0, "R1");
        expect_at(cyc, K_RUN,   0, 64'd0, "R1");
        expect_at(cyc, K_PEND,  0, 64'd0, "R1");
        expect_at(cyc, K_MIS,   0, 64'd0, "R1");
        expect_at(cyc, K_ERR,   0, 64'd0, "R1");
        for (int i = 0; i < NREG; i++) expect_at(cyc, K_REG, i, 64'd0, "R1");
        wait_cycles(2);

        // R5: SYNC with nothing pending, offset 0
        send_sync(s);
        expect_at(s + 2, K_ERR,   0, 64'd1, "R5");
        expect_at(s + 3, K_COUNT, 0, 64'd0, "R5");
        expect_at(s + 3, K_RUN,   0, 64'd0, "R5");
        wait_cycles(4);

        // R8 register writes, offset D=3
        send_cmd(8'h03, regwr_pl(8'd0, 32'd3), c);
        expect_at(c + 1, K_REG, 0, 64'd3, "R8");
        send_cmd(8'h03, regwr_pl(8'd2, 32'hDEAD_BEEF), c);
        expect_at(c + 1, K_REG, 2, 64'hDEAD_BEEF, "R8");
        send_cmd(8'h03, regwr_pl(8'd9, 32'h1234_5678), c);
        expect_at(c + 1, K_REG, 0, 64'd3, "R8");
        expect_at(c + 1, K_REG, 1, 64'd0, "R8");
        expect_at(c + 1, K_REG, 2, 64'hDEAD_BEEF, "R8");
        expect_at(c + 1, K_REG, 3, 64'd0, "R8");
        wait_cycles(2);

        // R2 preset does not start the counter
        send_cmd(8'h01, p1, c);
        expect_at(c + 1, K_PEND,  0, 64'd1, "R2");
        expect_at(c + 1, K_COUNT, 0, 64'd0, "R2");
        expect_at(c + 2, K_RUN,   0, 64'd0, "R2");
        wait_cycles(2);

        // R9 unknown opcode and opcode without valid
        send_cmd(8'h07, 64'h55, c);
        step();
        cmd_op = 8'h01;
        cmd_payload = 64'h9999;
        step();
        cmd_op = 8'h03;
        cmd_payload = regwr_pl(8'd0, 32'd0);
        step();
        cmd_op = 8'h00;
        cmd_payload = '0;
        expect_at(cyc, K_COUNT, 0, 64'd0, "R9");
        expect_at(cyc, K_PEND,  0, 64'd1, "R9");
        expect_at(cyc, K_REG,   0, 64'd3, "R9");
        wait_cycles(2);

        // R3/R4 load with offset 3: value appears at s+5
        send_sync(s);
        load_at = s + 5;
        expect_at(load_at - 1, K_COUNT, 0, 64'd0, "R4");
        expect_at(load_at, K_COUNT, 0, p1, "R4");
        expect_at(load_at, K_RUN,   0, 64'd1, "R3");
        expect_at(load_at, K_PEND,  0, 64'd0, "R3");
        expect_at(load_at + 7, K_COUNT, 0, p1 + 64'd7, "R3");
        wait_cycles(10);

        // R6 verify with the exact count
        step();
        c = cyc;
        cmd_valid = 1'b1;
        cmd_op = 8'h02;
        cmd_payload = p1 + 64'(c - load_at);
        step();
        cmd_valid = 1'b0;
        expect_at(c + 1, K_MIS, 0, 64'd0, "R6");
        expect_at(c + 3, K_MIS, 0, 64'd0, "R6");
        wait_cycles(3);

        // R6 verify with a wrong value, then sticky
        send_cmd(8'h02, 64'h1, c);
        expect_at(c + 1, K_MIS, 0, 64'd1, "R6");
        expect_at(c + 5, K_MIS, 0, 64'd1, "R6");
        wait_cycles(6);

        // R7 preset alone keeps the flag; load clears it (offset 0)
        send_cmd(8'h03, regwr_pl(8'd0, 32'd0), c);
        send_cmd(8'h01, p2, c);
        expect_at(c + 2, K_MIS, 0, 64'd1, "R7");
        wait_cycles(2);
        send_sync(s);
        expect_at(s + 1, K_MIS,   0, 64'd1, "R7");
        expect_at(s + 2, K_MIS,   0, 64'd0, "R7");
        expect_at(s + 2, K_COUNT, 0, p2, "R4");
        expect_at(s + 3, K_COUNT, 0, p2 + 64'd1, "R3");
        wait_cycles(4);

        // R10 second strobe inside the delay window (offset 5)
        send_cmd(8'h03, regwr_pl(8'd0, 32'd5), c);
        send_cmd(8'h01, p3, c);
        step();
        s = cyc;
        sync_in = 1'b1;
        step();
        sync_in = 1'b0;
        step();
        sync_in = 1'b1;
        step();
        sync_in = 1'b0;
        load_at = s + 7;
        expect_at(load_at, K_COUNT, 0, p3, "R10");
        expect_at(load_at + 10, K_COUNT, 0, p3 + 64'd10, "R3");
        expect_at(load_at + 5, K_ERR, 0, 64'd1, "R10");
        wait_cycles(12);

        // R5 orphan SYNC while running: count keeps stepping
        send_sync(s);
        expect_at(s + 8, K_ERR,   0, 64'd2, "R5");
        expect_at(s + 9, K_COUNT, 0, p3 + 64'(s + 9 - load_at), "R5");
        expect_at(s + 9, K_RUN,   0, 64'd1, "R5");
        wait_cycles(12);

        while (sbq.size() > 0) step();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule